// File: doc/BRIEF.md
# Polled Port Request Responder

This block is the peripheral-side answerer of a byte-wide polled port. The host side of the port runs poll cycles whenever it has no transaction of its own to run. On each poll the block replies with one response byte, driven while its acknowledge strobe is high. The byte tells the host which transaction the peripheral wants next. The choices are a DMA read of display data, a DMA write of compressed video data, an interrupt, or the return of register read data that an earlier split read left waiting.

Local sources raise single-cycle request pulses, and the block keeps them as sticky pending flags. When the host finishes a transaction it reports completion with a done pulse and a kind code, and the block drops the matching flag. Register read data captured on the local side is held for the read-receive transfer, and the capture marks read-data-ready as pending. Each poll reports only one request, chosen by a fixed priority in which display data always wins.

Top module: `poll_responder`

## Requirements
- R1: While `rst_n` is low, `ack_o` is 0, `resp_o` is 00h, `pend_o` is 0000b and `rdback_o` is 00h.
- R2: A poll accepted at a rising edge makes `ack_o` high for exactly ACK_LEN (default 2) cycles, starting right after that edge. `resp_o` stays unchanged throughout the strobe.
- R3: If nothing is pending when a poll is accepted, the response is 00h. Bits 7..5 of `resp_o` are always 0, and `resp_o` is 00h whenever `ack_o` is low.
- R4: The response is one-hot or zero. Display read sets bit 0, compressed-video write sets bit 1, interrupt sets bit 3, and read-data-ready sets bit 4.
- R5: When several requests are pending, only one is reported, in the priority order display, read-data-ready, compressed video, interrupt.
- R6: `pend_o` bit 0 is display, bit 1 is read-data-ready, bit 2 is compressed video and bit 3 is interrupt. A request bit is set on the edge after its request pulse. It stays set until a done of its own kind, and a done of any other kind leaves it alone.
- R7: A done pulse clears its flag on the same edge that samples it. If a new request of that kind arrives on that same edge, the flag stays set.
- R8: Read-data-ready is set only by `rd_cap_valid_i`. That pulse also loads `rd_cap_data_i` into `rdback_o`, which holds it. A done with kind 1 clears the flag and leaves `rdback_o` unchanged.
- R9: A poll sampled while `ack_o` is high is ignored. It neither restarts nor extends the strobe.
- R10: The response reflects the pending flags as they stood just before the accepting edge. Requests or completions during the strobe do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_i | input | 1 | Host starts a poll cycle |
| ack_o | output | 1 | Acknowledge strobe, response valid |
| resp_o | output | 8 | Poll response byte |
| disp_req_i | input | 1 | Display-data DMA read request pulse |
| vid_req_i | input | 1 | Compressed-video DMA write request pulse |
| irq_req_i | input | 1 | Interrupt request pulse |
| rd_cap_valid_i | input | 1 | Register read data captured locally |
| rd_cap_data_i | input | 8 | Captured register read data |
| done_i | input | 1 | Host reports a transaction complete |
| done_kind_i | input | 2 | Completed kind: 0 display, 1 read receive, 2 video, 3 interrupt |
| pend_o | output | 4 | Pending request flags |
| rdback_o | output | 8 | Held read data for the read-receive transfer |

## Verification
The properties assume that `done_kind_i` is meaningful only while `done_i` is high. They also assume that the host may poll at any time, including during a strobe, and that R9 covers that case. The properties make no assumption about request pulses lining up with completions. The same-edge set and clear case of R7 is therefore checked, not excluded. The stimulus drives every input from a free-running pseudo-random sequence, so polls, requests, captures and completions overlap in every combination. A directed sweep walks all sixteen pending patterns through a poll.

// File: rtl/poll_responder_pkg.sv
package poll_responder_pkg;

  localparam int NREQ   = 4;
  localparam int BYTE_W = 8;

  // slot order is the priority order, slot 0 highest
  typedef enum logic [1:0] {
    K_DISP = 2'd0,
    K_RDY  = 2'd1,
    K_VID  = 2'd2,
    K_IRQ  = 2'd3
  } xkind_e;

  // response bit position for each priority slot
  function automatic int slot_bit(input int slot);
    case (slot)
      0:       return 0;
      1:       return 4;
      2:       return 1;
      default: return 3;
    endcase
  endfunction

  // isolate the lowest-index set bit
  function automatic logic [NREQ-1:0] first_set(input logic [NREQ-1:0] v);
    logic [NREQ-1:0] r;
    logic            hit;
    r   = '0;
    hit = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (v[i] && !hit) begin
        r[i] = 1'b1;
        hit  = 1'b1;
      end
    end
    return r;
  endfunction

  // map a one-hot slot vector onto the response byte
  function automatic logic [BYTE_W-1:0] to_byte(input logic [NREQ-1:0] oh);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (oh[i]) r[slot_bit(i)] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/poll_pending.sv
module poll_pending
  import poll_responder_pkg::*;
#(
  parameter int N = NREQ
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] pend_q
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          pend_q[g] <= 1'b0;
      else if (set_v[g])   pend_q[g] <= 1'b1;
      else if (clr_v[g])   pend_q[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/poll_pick.sv
module poll_pick
  import poll_responder_pkg::*;
#(
  parameter int N = NREQ,
  parameter int W = BYTE_W
) (
  input  logic [N-1:0] pend,
  output logic [N-1:0] win_oh,
  output logic [W-1:0] code
);

  always_comb begin
    win_oh = first_set(pend);
    code   = W'(to_byte(win_oh));
  end

endmodule

// File: rtl/poll_ack_ctrl.sv
module poll_ack_ctrl #(
  parameter int W       = 8,
  parameter int ACK_LEN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         poll,
  input  logic [W-1:0] code_next,
  output logic         poll_take,
  output logic         ack,
  output logic [W-1:0] dout
);

  localparam int CNT_W = $clog2(ACK_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     snap_q;

  assign ack       = (cnt_q != '0);
  assign poll_take = poll && !ack;
  assign dout      = ack ? snap_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else if (poll_take) begin
      cnt_q  <= CNT_W'(ACK_LEN);
      snap_q <= code_next;
    end else if (ack) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/poll_responder.sv
module poll_responder
  import poll_responder_pkg::*;
#(
  parameter int ACK_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_i,
  output logic              ack_o,
  output logic [BYTE_W-1:0] resp_o,
  input  logic              disp_req_i,
  input  logic              vid_req_i,
  input  logic              irq_req_i,
  input  logic              rd_cap_valid_i,
  input  logic [BYTE_W-1:0] rd_cap_data_i,
  input  logic              done_i,
  input  logic [1:0]        done_kind_i,
  output logic [NREQ-1:0]   pend_o,
  output logic [BYTE_W-1:0] rdback_o
);

  logic [NREQ-1:0]   set_v;
  logic [NREQ-1:0]   clr_v;
  logic [NREQ-1:0]   pend_q;
  logic [NREQ-1:0]   win_oh;
  logic [BYTE_W-1:0] code_next;
  logic              poll_take;
  logic [BYTE_W-1:0] rd_hold_q;

  always_comb begin
    set_v         = '0;
    set_v[K_DISP] = disp_req_i;
    set_v[K_RDY]  = rd_cap_valid_i;
    set_v[K_VID]  = vid_req_i;
    set_v[K_IRQ]  = irq_req_i;
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_clr
    assign clr_v[g] = done_i && (done_kind_i == 2'(g));
  end

  poll_pending #(.N(NREQ)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_v  (set_v),
    .clr_v  (clr_v),
    .pend_q (pend_q)
  );

  poll_pick #(.N(NREQ), .W(BYTE_W)) u_pick (
    .pend   (pend_q),
    .win_oh (win_oh),
    .code   (code_next)
  );

  poll_ack_ctrl #(.W(BYTE_W), .ACK_LEN(ACK_LEN)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll      (poll_i),
    .code_next (code_next),
    .poll_take (poll_take),
    .ack       (ack_o),
    .dout      (resp_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)              rd_hold_q <= '0;
    else if (rd_cap_valid_i) rd_hold_q <= rd_cap_data_i;
  end

  assign pend_o   = pend_q;
  assign rdback_o = rd_hold_q;

endmodule

// File: rtl/poll_responder_chk.sv
module poll_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       poll_i,
  input logic       ack_o,
  input logic [7:0] resp_o,
  input logic [3:0] pend_q,
  input logic       disp_req_i,
  input logic       rd_cap_valid_i,
  input logic       done_i,
  input logic [1:0] done_kind_i,
  input logic       poll_take
);

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> resp_o == 8'h00);

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_o[7:5] == 3'b000);

  // R4
  onehot_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resp_o));

  // R2
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && $past(ack_o) |-> $stable(resp_o));

  // R2
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_take |=> ack_o);

  // R9
  busy_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !poll_take);

  // R5
  disp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_take && pend_q[0] |=> resp_o == 8'h01);

  // R7
  disp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && done_kind_i == 2'd0 && !disp_req_i |=> !pend_q[0]);

  // R8
  rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cap_valid_i && !pend_q[1] |=> !pend_q[1]);

endmodule

bind poll_responder poll_responder_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .poll_i         (poll_i),
  .ack_o          (ack_o),
  .resp_o         (resp_o),
  .pend_q         (pend_q),
  .disp_req_i     (disp_req_i),
  .rd_cap_valid_i (rd_cap_valid_i),
  .done_i         (done_i),
  .done_kind_i    (done_kind_i),
  .poll_take      (poll_take)
);

// File: tb/poll_responder_bench.sv
`timescale 1ns/1ps
module poll_responder_bench;

  localparam int ACK_LEN = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       poll_i = 1'b0;
  logic       ack_o;
  logic [7:0] resp_o;
  logic       disp_req_i = 1'b0, vid_req_i = 1'b0, irq_req_i = 1'b0;
  logic       rd_cap_valid_i = 1'b0;
  logic [7:0] rd_cap_data_i = 8'h00;
  logic       done_i = 1'b0;
  logic [1:0] done_kind_i = 2'd0;
  logic [3:0] pend_o;
  logic [7:0] rdback_o;

  int vectors = 0;
  int fails   = 0;
  bit ended   = 0;

  // model state
  logic [3:0] m_pend = 4'h0;
  logic [7:0] m_snap = 8'h00;
  logic [7:0] m_rdb  = 8'h00;
  int         m_cnt  = 0;

  always #2.5 clk = ~clk;

  poll_responder #(.ACK_LEN(ACK_LEN)) u_poll_responder (
    .clk(clk), .rst_n(rst_n), .poll_i(poll_i), .ack_o(ack_o), .resp_o(resp_o),
    .disp_req_i(disp_req_i), .vid_req_i(vid_req_i), .irq_req_i(irq_req_i),
    .rd_cap_valid_i(rd_cap_valid_i), .rd_cap_data_i(rd_cap_data_i),
    .done_i(done_i), .done_kind_i(done_kind_i), .pend_o(pend_o), .rdback_o(rdback_o)
  );

  // priority chain restated as nested choices
  function automatic logic [7:0] expect_code(input logic [3:0] p);
    if (p[0])      return 8'h01;
    else if (p[1]) return 8'h10;
    else if (p[2]) return 8'h02;
    else if (p[3]) return 8'h08;
    else           return 8'h00;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // rq: bit0 display, bit1 read capture, bit2 video, bit3 interrupt
  task automatic step(input logic p, input logic [3:0] rq, input logic [7:0] cd,
                      input logic dn, input logic [1:0] kd, input string tag);
    logic [3:0] nxt;
    @(negedge clk);
    poll_i = p; disp_req_i = rq[0]; rd_cap_valid_i = rq[1]; rd_cap_data_i = cd;
    vid_req_i = rq[2]; irq_req_i = rq[3]; done_i = dn; done_kind_i = kd;
    @(posedge clk);
    #1;
    if (p && m_cnt == 0) begin
      m_cnt  = ACK_LEN;
      m_snap = expect_code(m_pend);
    end else if (m_cnt > 0) begin
      m_cnt--;
    end
    for (int k = 0; k < 4; k++) begin
      nxt[k] = rq[k] | (m_pend[k] & ~(dn && kd == 2'(k)));
    end
    m_pend = nxt;
    if (rq[1]) m_rdb = cd;
    cmp(tag, "ack", int'(ack_o), int'(m_cnt != 0));
    cmp(tag, "resp", int'(resp_o), (m_cnt != 0) ? int'(m_snap) : 0);
    cmp(tag, "pend", int'(pend_o), int'(m_pend));
    cmp(tag, "rdback", int'(rdback_o), int'(m_rdb));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 8'h00, 1'b0, 2'd0, tag);
  endtask

  task automatic clear_all(input string tag);
    for (int k = 0; k < 4; k++) step(1'b0, 4'h0, 8'h00, 1'b1, 2'(k), tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    cmp("R1", "ack", int'(ack_o), 0);
    cmp("R1", "resp", int'(resp_o), 0);
    cmp("R1", "pend", int'(pend_o), 0);
    cmp("R1", "rdback", int'(rdback_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 empty poll gives 00h
    step(1'b1, 4'h0, 8'h00, 1'b0, 2'd0, "R3");
    idle(3, "R3");

    // R4 / R5 sweep all pending patterns through a poll
    for (int c = 0; c < 16; c++) begin
      clear_all("R5");
      step(1'b0, 4'(c), 8'(c * 17), 1'b0, 2'd0, "R4");
      step(1'b1, 4'h0, 8'h00, 1'b0, 2'd0, "R5");
      idle(ACK_LEN + 1, "R2");
    end

    // R6 sticky against foreign completions
    clear_all("R6");
    step(1'b0, 4'b0100, 8'h00, 1'b0, 2'd0, "R6");
    for (int k = 0; k < 4; k++) if (k != 2) step(1'b0, 4'h0, 8'h00, 1'b1, 2'(k), "R6");
    step(1'b0, 4'h0, 8'h00, 1'b1, 2'd2, "R6");

    // R7 same-edge request beats completion
    step(1'b0, 4'b0001, 8'h00, 1'b0, 2'd0, "R7");
    step(1'b0, 4'b0001, 8'h00, 1'b1, 2'd0, "R7");
    step(1'b0, 4'b0000, 8'h00, 1'b1, 2'd0, "R7");

    // R8 capture, readback held, cleared by read receive
    step(1'b0, 4'b0010, 8'hA5, 1'b0, 2'd0, "R8");
    step(1'b1, 4'h0, 8'h00, 1'b0, 2'd0, "R8");
    idle(ACK_LEN, "R8");
    step(1'b0, 4'h0, 8'h00, 1'b1, 2'd1, "R8");

    // R9 poll during strobe ignored
    step(1'b0, 4'b1000, 8'h00, 1'b0, 2'd0, "R9");
    step(1'b1, 4'h0, 8'h00, 1'b0, 2'd0, "R9");
    step(1'b1, 4'b0001, 8'h00, 1'b0, 2'd0, "R9");
    step(1'b1, 4'h0, 8'h00, 1'b0, 2'd0, "R9");
    idle(2, "R9");

    // R10 changes during strobe do not alter response
    clear_all("R10");
    step(1'b0, 4'b0100, 8'h00, 1'b0, 2'd0, "R10");
    step(1'b1, 4'b0001, 8'h00, 1'b0, 2'd0, "R10");
    step(1'b0, 4'b1000, 8'h00, 1'b1, 2'd2, "R10");
    idle(2, "R10");

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[5],
           {lfsr[3] & lfsr[9], lfsr[2] & lfsr[8], lfsr[7] & lfsr[11], lfsr[1] & lfsr[6]},
           lfsr[15:8], lfsr[4] & lfsr[12], lfsr[14:13], "R6");
    end

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule